// File: doc/BRIEF.md
# Kernel Stack Limit Checker

This block sits next to the address path of a 16-bit processor and judges each data access made through the stack pointer against a programmable lower stack bound. The processor presents the current mode, the base register number and the addressing mode of the operand specifier, a write indication and the effective virtual address. The checker answers in the same cycle with one of two warnings. The yellow warning asks for a trap after the instruction completes. The red warning asks for an abort that needs an emergency stack.

Checking is armed only in kernel mode, only for writes, and only for specifiers that use the stack pointer with register-deferred, autoincrement, autodecrement or indexed addressing. The bound is an 8-bit register that supplies the upper byte of the lowest legal stack address. The warning window occupies the top 32 bytes of the 256-byte page just above that address. Everything below the window is red. The word holding the processor status, at 177776 octal, is always red while checking is armed. This keeps a push made with the stack pointer at zero from overwriting the status word.

Top module: `stk_limit_chk`

## Requirements
- R1: The bound register `bound_q` reads 0 after reset. When `bound_we` is high at a rising clock edge, `bound_q` takes `bound_wdata` after that edge; otherwise it holds its value. An access is always judged against the bound value that is present before the edge.
- R2: Checking is armed only when `cpu_mode` is 2'b00 (kernel). The encodings 2'b01, 2'b10 and 2'b11 never raise a flag.
- R3: Only specifiers whose `spec_reg` is 6 (the stack pointer) are checked. Any other register number never raises a flag.
- R4: Only writes (`acc_write` = 1) are checked. A read in any addressing mode, including autodecrement, never raises a flag.
- R5: The `spec_mode` values 1, 2, 4 and 6 are checked. The values 0, 3, 5 and 7 never raise a flag.
- R6: With checking armed and B = `bound_q` × 256, an address below B + 0340 octal raises `zone_red`.
- R7: With checking armed, an address from B + 0340 to B + 0377 octal inclusive, other than 177776 octal, raises `zone_yellow`.
- R8: With checking armed, an address above B + 0377 octal, other than 177776 octal, raises no flag.
- R9: With checking armed, address 177776 octal raises `zone_red` for every bound value, including when it falls inside the yellow window.
- R10: Both flags are 0 whenever `acc_valid` is 0, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bound_we | input | 1 | Write strobe for the bound register |
| bound_wdata | input | 8 | New bound (upper address byte) |
| bound_q | output | 8 | Current bound register value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read |
| cpu_mode | input | 2 | Processor mode, 2'b00 = kernel |
| spec_reg | input | 3 | Base register number of the specifier |
| spec_mode | input | 3 | Addressing mode of the specifier (0 to 7) |
| eff_addr | input | 16 | Virtual effective address |
| zone_yellow | output | 1 | Warning: trap after the instruction |
| zone_red | output | 1 | Fatal: abort and switch to the emergency stack |

## Verification
Two functions can meet in one cycle. The first is a bound write colliding with an armed access, which must be judged against the old bound. The bench provokes this with directed cycles that raise `bound_we` while an address lies in the yellow window of the old bound but in a different zone under the new one. Its reference model updates its copy of the bound only after the edge. The second is the status-word address falling inside the yellow window when the bound is 0377 octal. That cycle is forced directly, and only the red flag may appear.

// File: rtl/stk_limit_chk.sv
module stk_limit_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          BOUND_W    = 8,
  parameter int          MODE_W     = 2,
  parameter int          REG_W      = 3,
  parameter int          AMODE_W    = 3,
  parameter logic [2:0]  SP_REG     = 3'd6,
  parameter logic [1:0]  KERNEL     = 2'b00,
  parameter logic [7:0]  AMODE_MASK = 8'b0101_0110,
  parameter int          YEL_OFS    = 'o340
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bound_we,
  input  logic [BOUND_W-1:0] bound_wdata,
  output logic [BOUND_W-1:0] bound_q,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [MODE_W-1:0]  cpu_mode,
  input  logic [REG_W-1:0]   spec_reg,
  input  logic [AMODE_W-1:0] spec_mode,
  input  logic [ADDR_W-1:0]  eff_addr,
  output logic               zone_yellow,
  output logic               zone_red
);
  localparam int PAGE_W = ADDR_W - BOUND_W;
  localparam int YEL_TOP = (1 << PAGE_W) - 1;
  localparam logic [ADDR_W-1:0] PSW_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [ADDR_W:0] base, yel_lo, yel_hi, addr_x;
  logic armed, is_psw, below, in_win;

  always_ff @(posedge clk) begin
    if (!rst_n)        bound_q <= '0;
    else if (bound_we) bound_q <= bound_wdata;
  end

  assign base   = {1'b0, bound_q, {PAGE_W{1'b0}}};
  assign yel_lo = base + (ADDR_W+1)'(YEL_OFS);
  assign yel_hi = base + (ADDR_W+1)'(YEL_TOP);
  assign addr_x = {1'b0, eff_addr};

  assign armed  = acc_valid && acc_write && (cpu_mode == KERNEL)
                  && (spec_reg == SP_REG) && AMODE_MASK[spec_mode];
  assign is_psw = (eff_addr == PSW_ADDR);
  assign below  = addr_x < yel_lo;
  assign in_win = !below && (addr_x <= yel_hi);

  assign zone_red    = armed && (below || is_psw);
  assign zone_yellow = armed && in_win && !is_psw;

  // R2
  user_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode != KERNEL) |-> !(zone_red || zone_yellow));

  // R4
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !(zone_red || zone_yellow));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(zone_red || zone_yellow));

  // R10
  one_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zone_red, zone_yellow}));

  // R1
  bound_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bound_we |=> (bound_q == $past(bound_wdata)));

  // R1
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_we |=> $stable(bound_q));

  // R9
  psw_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && cpu_mode == KERNEL && spec_reg == SP_REG
     && AMODE_MASK[spec_mode] && eff_addr == PSW_ADDR) |-> zone_red);
endmodule

// File: tb/sim_stk_limit_chk.sv
module sim_stk_limit_chk;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bound_we = 1'b0;
  logic [7:0] bound_wdata = '0, bound_q;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] cpu_mode = '0;
  logic [2:0] spec_reg = '0, spec_mode = '0;
  logic [15:0] eff_addr = '0;
  logic zone_yellow, zone_red;

  int checks = 0, fails = 0;
  logic [7:0] m_bound = '0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  stk_limit_chk u0 (
    .clk(clk), .rst_n(rst_n), .bound_we(bound_we), .bound_wdata(bound_wdata),
    .bound_q(bound_q), .acc_valid(acc_valid), .acc_write(acc_write),
    .cpu_mode(cpu_mode), .spec_reg(spec_reg), .spec_mode(spec_mode),
    .eff_addr(eff_addr), .zone_yellow(zone_yellow), .zone_red(zone_red));

  // returns {red, yellow}
  function automatic logic [1:0] ref_zone(logic v, logic w, logic [1:0] m,
      logic [2:0] r, logic [2:0] am, logic [15:0] a, logic [7:0] b);
    int lo;
    if (!(v && w && m == 2'b00 && r == 3'd6 &&
          (am == 3'd1 || am == 3'd2 || am == 3'd4 || am == 3'd6)))
      return 2'b00;
    lo = int'(b) * 256;
    if (a == 16'o177776 || int'(a) < lo + 'o340) return 2'b10;
    if (int'(a) <= lo + 'o377) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, compare flags before posedge, update model after it
  task automatic step(string tag, logic v, logic w, logic [1:0] m, logic [2:0] r,
      logic [2:0] am, logic [15:0] a, logic we = 1'b0, logic [7:0] wd = 8'h00);
    @(negedge clk);
    acc_valid = v; acc_write = w; cpu_mode = m; spec_reg = r;
    spec_mode = am; eff_addr = a; bound_we = we; bound_wdata = wd;
    #1;
    chk(tag, {14'd0, zone_red, zone_yellow}, {14'd0, ref_zone(v, w, m, r, am, a, m_bound)});
    @(posedge clk);
    if (we) m_bound = wd;
    #1;
    bound_we = 1'b0;
  endtask

  task automatic set_bound(logic [7:0] b);
    step("R1 load", 1'b0, 1'b0, 2'b00, 3'd0, 3'd0, 16'h0, 1'b1, b);
    chk("R1 readback", {8'd0, bound_q}, {8'd0, b});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset bound", {8'd0, bound_q}, 16'd0);
    chk("R10 reset flags", {14'd0, zone_red, zone_yellow}, 16'd0);
    rst_n = 1'b1;

    // default bound 0: window 0340..0377
    step("R6 red below", 1, 1, 2'b00, 3'd6, 3'd4, 16'o000336);
    step("R7 yellow lo", 1, 1, 2'b00, 3'd6, 3'd4, 16'o000340);
    step("R7 yellow hi", 1, 1, 2'b00, 3'd6, 3'd2, 16'o000377);
    step("R8 clean", 1, 1, 2'b00, 3'd6, 3'd6, 16'o000400);
    step("R9 psw", 1, 1, 2'b00, 3'd6, 3'd1, 16'o177776);
    step("R4 read dec", 1, 0, 2'b00, 3'd6, 3'd4, 16'o000100);
    step("R2 user", 1, 1, 2'b11, 3'd6, 3'd4, 16'o000100);
    step("R2 super", 1, 1, 2'b01, 3'd6, 3'd4, 16'o000100);
    step("R3 other reg", 1, 1, 2'b00, 3'd5, 3'd4, 16'o000100);
    step("R10 idle", 0, 1, 2'b00, 3'd6, 3'd4, 16'o000100);
    for (int am = 0; am < 8; am++)
      step("R5 mode sweep", 1, 1, 2'b00, 3'd6, 3'(am), 16'o000010);

    // same-cycle bound write: judged on old bound (0)
    step("R1 old bound", 1, 1, 2'b00, 3'd6, 3'd4, 16'o000350, 1'b1, 8'h10);
    chk("R1 new bound", {8'd0, bound_q}, 16'h0010);
    step("R6 new bound", 1, 1, 2'b00, 3'd6, 3'd4, 16'o000350);
    step("R7 new window", 1, 1, 2'b00, 3'd6, 3'd6, 16'h10E0);

    set_bound(8'hFF);
    step("R9 psw in window", 1, 1, 2'b00, 3'd6, 3'd2, 16'o177776);
    step("R7 top", 1, 1, 2'b00, 3'd6, 3'd2, 16'hFFFF);
    step("R7 near top", 1, 1, 2'b00, 3'd6, 3'd2, 16'hFFE0);
    step("R6 under top", 1, 1, 2'b00, 3'd6, 3'd2, 16'hFFDF);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic we;
      we = ($urandom % 8) == 0;
      if ($urandom % 2) a = {m_bound, 8'h00} + 16'($urandom % 512) - 16'd32;
      else if (($urandom % 16) == 0) a = 16'o177776;
      else a = 16'($urandom);
      step("R6 R7 R8 random",
           ($urandom % 8) != 0, ($urandom % 4) != 0,
           (($urandom % 3) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 4) == 0) ? 3'($urandom) : 3'd6,
           3'($urandom), a, we, 8'($urandom));
      chk("R1 random bound", {8'd0, bound_q}, {8'd0, m_bound});
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 150000);
        fails++; checks++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule